// File: doc/BRIEF.md
# Decimating Read Sequencer for a Chained ADC Group

This block collects one result out of every `DECIM_N` from a group of four delta-sigma converters wired as a daisy chain. Every converter shares chip select, serial clock, command input, the conversion-start line and its conversion clock. Their results therefore become ready on the same cycle, and one active-low ready line is enough to follow the whole group. Each converter's serial output feeds the daisy input of its neighbour. The converter nearest the controller drives the single MISO line, and the far end of the chain has its daisy input tied low.

The sequencer synchronises the ready line and counts its high-to-low transitions. When the `DECIM_N-1`th transition arrives, it pulls the start line low so that conversions stop. It then stays quiet for one full data-rate period. The controller takes no notice of any ready pulse that appears in this window. Next it lowers chip select, sends an 8-bit read command and clocks in 128 result bits, 32 per converter. It publishes the result bits as four words with a single-cycle strobe. Finally it raises the start line again and clears its event counter. Because conversions are held off before and during the transfer, no fresh result can land in the converters' output registers while the transfer is running. For the same reason, no serial-clock edge can fall just ahead of a ready edge.

Top module: `chain_read_seq`

## Requirements
- R1: While reset is asserted, and on leaving it, `startPin` is 1, `csN` is 1, `sclk` is 0 and `wordsValid` is 0. Asserting reset during the quiet period returns `startPin` to 1.
- R2: A high-to-low transition of `drdyN` counts as exactly one ready event, however long the line then stays low. After fewer than `DECIM_N-1` events, `startPin` stays 1.
- R3: `drdyN` is sampled on the rising clock edge. When the sampled value is the low of the `DECIM_N-1`th event, `startPin` goes to 0 on the third rising clock edge after that sample, counting the sampling edge.
- R4: For `PERIOD_CYC` clock cycles after `startPin` falls, `csN` stays 1 and `sclk` makes no edge. Any `drdyN` activity in this window is ignored. `csN` falls exactly `PERIOD_CYC` cycles after `startPin` falls.
- R5: During the first 8 serial clocks, `mosi` carries the command `READ_CMD` (default 8'h12), most significant bit first. `mosi` changes after a rising `sclk` edge and is stable at the falling edge.
- R6: Exactly `8 + 128` serial clocks are produced per read. `sclk` idles at 0, and each half period lasts `SCLK_DIV` clock cycles.
- R7: `miso` is sampled on each falling `sclk` edge, and only the last 128 bits are kept. Word k of the output is the k-th 32-bit group received, MSB first, and it sits at `wordsOut[32k+31:32k]`. `wordsValid` is 1 for one cycle, in the cycle after the last falling `sclk` edge, and `csN` is already 1 in that cycle.
- R8: In the cycle after `wordsValid`, `startPin` is 1 and the event count is zero. The next read therefore begins only after exactly `DECIM_N-1` new transitions, and pulses seen during the quiet period do not count towards it.
- R9: `sclk` is 1 only while `csN` is 0, and `startPin` is 0 whenever `csN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| drdyN | input | 1 | Shared active-low data-ready line |
| miso | input | 1 | Serial data from the first converter of the chain |
| startPin | output | 1 | Conversion start line, high to run |
| csN | output | 1 | Shared active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial command data |
| wordsOut | output | 128 | Four received 32-bit words, word 0 in the low bits |
| wordsValid | output | 1 | One-cycle strobe marking new `wordsOut` |

## Verification
The ready line passes through two synchroniser flops and one edge flop, so the start line is due low after the third rising edge. The bench therefore checks it once after two edges, expecting high, and once after three, expecting low. The quiet window is checked at every falling clock edge during the `PERIOD_CYC` cycles that follow. The bench then expects chip select low at exactly the next falling edge. The bench drives MISO right after each rising serial-clock edge and reads MOSI at each falling edge. The word strobe and the released chip select are checked at the first falling clock edge after the last serial fall, and the restored start line one cycle later.

// File: rtl/chain_read_pkg.sv
package chain_read_pkg;
  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_QUIET = 2'd1,
    ST_XFER  = 2'd2,
    ST_DONE  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic load;     // prime divider and shift registers
    logic run;      // serial transfer active
    logic publish;  // result words are complete
  } seqStrobe_t;
endpackage

// File: rtl/chain_read_ctrl.sv
module chain_read_ctrl
  import chain_read_pkg::*;
#(
  parameter int DECIM_N    = 4,
  parameter int PERIOD_CYC = 288
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       drdyN,
  input  logic       bitsDone,
  output seqStrobe_t strobe,
  output logic       startPin,
  output logic       csN
);
  localparam int EV_W  = (DECIM_N > 2) ? $clog2(DECIM_N) : 1;
  localparam int TMR_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [EV_W-1:0]  LAST_EV  = EV_W'(DECIM_N - 2);
  localparam logic [TMR_W-1:0] LAST_TMR = TMR_W'(PERIOD_CYC - 1);

  seqState_t       state;
  logic [2:0]      syncQ;
  logic [EV_W-1:0] evCnt;
  logic [TMR_W-1:0] quietTmr;
  logic            readyFall;
  logic            quietOver;

  // two synchroniser stages plus one edge stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 3'b111;
    else       syncQ <= {syncQ[1:0], drdyN};
  end

  assign readyFall = syncQ[2] & ~syncQ[1];
  assign quietOver = (state == ST_QUIET) && (quietTmr == LAST_TMR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_COUNT;
      evCnt    <= '0;
      quietTmr <= '0;
    end else begin
      unique case (state)
        ST_COUNT: if (readyFall) begin
          if (evCnt == LAST_EV) begin
            state    <= ST_QUIET;
            quietTmr <= '0;
          end else begin
            evCnt <= evCnt + 1'b1;
          end
        end
        ST_QUIET: begin
          quietTmr <= quietTmr + 1'b1;
          if (quietOver) state <= ST_XFER;
        end
        ST_XFER: if (bitsDone) state <= ST_DONE;
        ST_DONE: begin
          state <= ST_COUNT;
          evCnt <= '0;
        end
        default: state <= ST_COUNT;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = quietOver;
    strobe.run     = (state == ST_XFER);
    strobe.publish = (state == ST_DONE);
  end

  assign startPin = (state == ST_COUNT) || (state == ST_DONE);
  assign csN      = (state != ST_XFER);
endmodule

// File: rtl/chain_read_dp.sv
module chain_read_dp
  import chain_read_pkg::*;
#(
  parameter int               CMD_W    = 8,
  parameter logic [CMD_W-1:0] READ_CMD = 8'h12,
  parameter int               NUM_DEV  = 4,
  parameter int               WORD_W   = 32,
  parameter int               SCLK_DIV = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobe,
  input  logic                      miso,
  output logic                      sclk,
  output logic                      mosi,
  output logic                      bitsDone,
  output logic [NUM_DEV*WORD_W-1:0] wordsOut,
  output logic                      wordsValid
);
  localparam int RX_W  = NUM_DEV * WORD_W;
  localparam int TOTAL = CMD_W + RX_W;
  localparam int BIT_W = $clog2(TOTAL + 1);
  localparam int DIV_W = $clog2(SCLK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(SCLK_DIV - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TOTAL - 1);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [CMD_W-1:0] cmdReg;
  logic [RX_W-1:0]  rxReg;
  logic             sclkR, mosiR, halfEnd;

  assign halfEnd = strobe.run && (divCnt == DIV_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bitCnt <= '0;
      cmdReg <= '0;
      rxReg  <= '0;
      sclkR  <= 1'b0;
      mosiR  <= 1'b0;
    end else if (strobe.load) begin
      divCnt <= '0;
      bitCnt <= '0;
      cmdReg <= READ_CMD;
      sclkR  <= 1'b0;
      mosiR  <= 1'b0;
    end else if (strobe.run) begin
      if (halfEnd) begin
        divCnt <= '0;
        sclkR  <= ~sclkR;
        if (!sclkR) begin
          mosiR  <= cmdReg[CMD_W-1];
          cmdReg <= {cmdReg[CMD_W-2:0], 1'b0};
        end else begin
          rxReg  <= {rxReg[RX_W-2:0], miso};
          bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end else begin
      sclkR <= 1'b0;
      mosiR <= 1'b0;
    end
  end

  assign bitsDone = halfEnd && sclkR && (bitCnt == LAST_BIT);

  // first received group lands in word 0
  for (genvar g = 0; g < NUM_DEV; g++) begin : gWord
    assign wordsOut[g*WORD_W +: WORD_W] = rxReg[RX_W-1-g*WORD_W -: WORD_W];
  end

  assign wordsValid = strobe.publish;
  assign sclk       = sclkR;
  assign mosi       = mosiR;
endmodule

// File: rtl/chain_read_seq.sv
module chain_read_seq
  import chain_read_pkg::*;
#(
  parameter int         DECIM_N    = 4,
  parameter int         PERIOD_CYC = 288,
  parameter int         SCLK_DIV   = 2,
  parameter logic [7:0] READ_CMD   = 8'h12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         drdyN,
  input  logic         miso,
  output logic         startPin,
  output logic         csN,
  output logic         sclk,
  output logic         mosi,
  output logic [127:0] wordsOut,
  output logic         wordsValid
);
  seqStrobe_t strobe;
  logic       bitsDone;

  chain_read_ctrl #(.DECIM_N(DECIM_N), .PERIOD_CYC(PERIOD_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .drdyN(drdyN), .bitsDone(bitsDone),
    .strobe(strobe), .startPin(startPin), .csN(csN)
  );

  chain_read_dp #(.CMD_W(8), .READ_CMD(READ_CMD), .NUM_DEV(4), .WORD_W(32),
                  .SCLK_DIV(SCLK_DIV)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .miso(miso),
    .sclk(sclk), .mosi(mosi), .bitsDone(bitsDone),
    .wordsOut(wordsOut), .wordsValid(wordsValid)
  );
endmodule

// File: rtl/chain_read_seq_chk.sv
module chain_read_seq_chk #(
  parameter int PERIOD_CYC = 288
) (
  input logic clk,
  input logic rstN,
  input logic startPin,
  input logic csN,
  input logic sclk,
  input logic wordsValid
);
  localparam int QW = $clog2(PERIOD_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(PERIOD_CYC);

  logic [QW-1:0] quietCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 quietCnt <= '0;
    else if (startPin)         quietCnt <= '0;
    else if (quietCnt != QMAX) quietCnt <= quietCnt + 1'b1;
  end

  // R4: no serial clock before the quiet period has elapsed
  assert_quiet_before_clock_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> (quietCnt == QMAX));

  // R9: serial clock only inside the selected transfer
  assert_sclk_inside_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  // R9: conversions held off while selected
  assert_start_low_in_xfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !startPin);

  // R7: strobe lasts one cycle and follows deselect
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordsValid |=> !wordsValid);
  assert_valid_deselected_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordsValid |-> csN);

  // R8: start line restored right after the result strobe
  assert_restart_after_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordsValid |=> startPin);
endmodule

bind chain_read_seq chain_read_seq_chk #(.PERIOD_CYC(PERIOD_CYC)) uChk (
  .clk(clk), .rstN(rstN), .startPin(startPin), .csN(csN),
  .sclk(sclk), .wordsValid(wordsValid)
);

// File: tb/chain_read_seq_test.sv
module chain_read_seq_test;
  localparam int         N_EV   = 4;
  localparam int         PERIOD = 40;
  localparam int         DIV    = 2;
  localparam logic [7:0] CMD    = 8'h12;
  localparam int         NVEC   = 3;

  // stimulus: received order, first converter first; expected: word 0 in low bits
  localparam logic [127:0] STIM [NVEC] = '{
    128'h01234567_89ABCDEF_FEDCBA98_76543210,
    128'hFFFFFFFF_00000000_AAAAAAAA_55555555,
    128'h80000001_7FFFFFFE_0000FFFF_C3C3C3C3
  };
  localparam logic [127:0] EXPW [NVEC] = '{
    128'h76543210_FEDCBA98_89ABCDEF_01234567,
    128'h55555555_AAAAAAAA_00000000_FFFFFFFF,
    128'hC3C3C3C3_0000FFFF_7FFFFFFE_80000001
  };

  logic clk = 1'b0, rstN = 1'b0, drdyN = 1'b1, miso = 1'b0;
  logic startPin, csN, sclk, mosi, wordsValid;
  logic [127:0] wordsOut;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chain_read_seq #(.DECIM_N(N_EV), .PERIOD_CYC(PERIOD), .SCLK_DIV(DIV), .READ_CMD(CMD)) uut (
    .clk(clk), .rstN(rstN), .drdyN(drdyN), .miso(miso),
    .startPin(startPin), .csN(csN), .sclk(sclk), .mosi(mosi),
    .wordsOut(wordsOut), .wordsValid(wordsValid)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readyPulse();
    @(negedge clk) drdyN = 1'b0;
    repeat (4) @(negedge clk);
    drdyN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic doRead(input int v);
    logic [7:0] mosiCap = '0;
    bit quietOk = 1;
    bit idleOk = 1;
    // last event: the low is sampled at the next rising edge
    @(negedge clk) drdyN = 1'b0;
    repeat (2) @(negedge clk);
    check(startPin == 1'b1, "R3 start still high after two edges", 128'(startPin), 128'd1);
    @(negedge clk);
    check(startPin == 1'b0, "R3 start low after third edge", 128'(startPin), 128'd0);
    for (int i = 0; i < PERIOD - 1; i++) begin
      if (i == 2)  drdyN = 1'b1;
      if (i == 10) drdyN = 1'b0;   // stray pulse, ignored
      if (i == 14) drdyN = 1'b1;
      if (!(csN && !sclk)) quietOk = 0;
      @(negedge clk);
    end
    check(quietOk, "R4 quiet window", 128'(quietOk), 128'd1);
    @(negedge clk);
    check(csN == 1'b0 && sclk == 1'b0, "R4 select after period", {126'd0, csN, sclk}, 128'd0);
    for (int b = 0; b < 136; b++) begin
      @(posedge sclk);
      miso = (b < 8) ? 1'b1 : STIM[v][127 - (b - 8)];
      @(negedge sclk);
      if (b < 8) mosiCap = {mosiCap[6:0], mosi};
    end
    @(negedge clk);
    check(wordsValid == 1'b1 && csN == 1'b1, "R7 strobe with select released",
          {126'd0, wordsValid, csN}, 128'd3);
    check(wordsOut == EXPW[v], "R7 R6 received words", wordsOut, EXPW[v]);
    check(mosiCap == CMD, "R5 command bits", 128'(mosiCap), 128'(CMD));
    @(negedge clk);
    check(wordsValid == 1'b0 && startPin == 1'b1, "R8 restart after read",
          {126'd0, wordsValid, startPin}, 128'd1);
    for (int i = 0; i < 12; i++) begin
      if (!(csN && !sclk)) idleOk = 0;
      @(negedge clk);
    end
    check(idleOk, "R6 no extra serial clocks", 128'(idleOk), 128'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(startPin && csN && !sclk && !wordsValid, "R1 reset outputs",
          {124'd0, startPin, csN, sclk, wordsValid}, 128'b1100);
    rstN = 1'b1;
    @(negedge clk);
    check(startPin && csN && !sclk && !wordsValid, "R1 after reset release",
          {124'd0, startPin, csN, sclk, wordsValid}, 128'b1100);

    for (int v = 0; v < NVEC; v++) begin
      if (v == 0) begin
        // one long low counts once
        drdyN = 1'b0;
        repeat (25) @(negedge clk);
        drdyN = 1'b1;
        repeat (5) @(negedge clk);
      end else begin
        readyPulse();
      end
      check(startPin == 1'b1, "R2 after first event", 128'(startPin), 128'd1);
      readyPulse();
      check(startPin == 1'b1, "R2 R8 after second event", 128'(startPin), 128'd1);
      doRead(v);
    end

    // reset in the middle of the quiet period
    readyPulse();
    readyPulse();
    readyPulse();
    repeat (5) @(negedge clk);
    check(startPin == 1'b0, "R3 entered quiet period", 128'(startPin), 128'd0);
    rstN = 1'b0;
    @(negedge clk);
    check(startPin && csN && !sclk, "R1 reset during quiet period",
          {125'd0, startPin, csN, sclk}, 128'b110);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule